// File: doc/BRIEF.md
# Programmable Bartlett Averaging Filter

This block smooths a stream of 14-bit two's-complement samples with a triangular (Bartlett) response. The triangle is produced by running the stream through two identical boxcar averagers in series. Each averager holds a running sum and a circular delay memory. The window length is N = 2^M, where M is a programmable exponent. A measurement-range code can force a larger minimum window. Each accepted sample yields one filtered result two clock cycles later, once the filter has seen enough samples to fill both windows.

The exponent is taken from a 4-bit field and limited to 7, which gives 128 taps at most. Two range codes raise the exponent to a floor value. Any change to either setting restarts the filter from an empty state. Both averaging steps divide by N with rounding toward negative infinity. An exponent of zero therefore passes samples through unchanged.

Top module: `bart_filter`

## Requirements
- R1: While reset is held and after it is released, filt_valid is 0 until the warm-up condition of R4 is met.
- R2: With an effective exponent of 0 (N = 1), filt_data equals the sample accepted two clock edges earlier, and it is valid from the first accepted sample onward.
- R3: Define the stage-one value for sample k as floor(sum of the last N accepted samples up to k, divided by N). Samples before the most recent clear count as zero. filt_data for sample k is floor(sum of the last N stage-one values, divided by N). It appears two clock edges after the edge that accepted sample k.
- R4: filt_valid is 1 only for accepted samples from the (2N-1)-th after the most recent clear. Each such sample produces exactly one valid output.
- R5: A tap_log2 value above 7 behaves as 7 (N = 128).
- R6: range_sel = 3'b010 raises the effective exponent to at least 2.
- R7: range_sel = 3'b001 raises the effective exponent to at least 4. All other range_sel codes impose no minimum.
- R8: A change in tap_log2 or range_sel empties both averaging stages and restarts the warm-up count. A sample presented in the same cycle as the change is discarded. filt_valid is 0 in that cycle and in the next one.
- R9: The running sums do not overflow. A constant input of +8191 or of -8192 at N = 128 produces exactly that value at the output.
- R10: Cycles with smp_valid = 0 do not advance either stage. The output depends only on the accepted samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe, one sample per cycle in which it is high |
| smp_data | input | 14 | Sample, two's complement |
| tap_log2 | input | 4 | Requested window exponent M |
| range_sel | input | 3 | Measurement-range code (001 and 010 impose minimum exponents) |
| filt_valid | output | 1 | Filtered result is valid |
| filt_data | output | 14 | Filtered result, two's complement |

## Verification
Every exponent from 0 to 7 is driven with three kinds of stream:
- A pseudo-random full-scale sequence shows whether the two-stage floor arithmetic is right for arbitrary values.
- Alternating extremes expose sign-extension and rounding faults at the window edges.
- A stepped ramp broken by idle cycles shows whether empty cycles wrongly advance the delay lines.

Long constant streams at both full-scale limits with 128 taps probe the width of the running sums. Further runs change the settings to show whether each clamp and range floor takes effect. A further run changes the settings together with a sample, to show whether stale history or the coinciding sample leaks into the new outputs.

// File: rtl/bart_pkg.sv
package bart_pkg;

  // Range codes that impose a floor on the window exponent.
  localparam int unsigned RNG_FINE_CODE = 1;
  localparam int unsigned RNG_MID_CODE  = 2;
  localparam int unsigned FINE_FLOOR    = 4;
  localparam int unsigned MID_FLOOR     = 2;

  // Effective exponent: clamp the request to max_m, then apply the range floor.
  function automatic int unsigned eff_log2(input int unsigned req,
                                           input int unsigned rng,
                                           input int unsigned max_m);
    int unsigned m;
    int unsigned lo;
    lo = 0;
    if (rng == RNG_FINE_CODE) lo = FINE_FLOOR;
    else if (rng == RNG_MID_CODE) lo = MID_FLOOR;
    m = (req > max_m) ? max_m : req;
    if (m < lo) m = lo;
    if (m > max_m) m = max_m;
    return m;
  endfunction

  // Samples that must emerge before the next one is a full two-stage result.
  function automatic int unsigned warm_need(input int unsigned m);
    return (32'd2 << m) - 32'd2;
  endfunction

endpackage

// File: rtl/bart_cfg.sv
module bart_cfg #(
  parameter int TAP_W = 4,
  parameter int RNG_W = 3,
  parameter int MAX_M = 7,
  parameter int EW    = $clog2(MAX_M + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAP_W-1:0] tap_req,
  input  logic [RNG_W-1:0] rng_req,
  output logic             clr,
  output logic [EW-1:0]    m_eff
);
  import bart_pkg::*;

  localparam int RAW_W = TAP_W + RNG_W;

  logic [RAW_W-1:0] raw_q;
  logic [RAW_W-1:0] raw_now;
  logic [EW-1:0]    m_nx;

  assign raw_now = {tap_req, rng_req};
  assign clr     = (raw_now != raw_q);
  assign m_nx    = EW'(eff_log2(32'(tap_req), 32'(rng_req), MAX_M));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      m_eff <= '0;
    end else begin
      raw_q <= raw_now;
      m_eff <= m_nx;
    end
  end
endmodule

// File: rtl/bart_stage.sv
module bart_stage #(
  parameter int DW    = 14,
  parameter int MAX_M = 7,
  parameter int EW    = $clog2(MAX_M + 1),
  parameter int SW    = DW + MAX_M + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [EW-1:0]        m,
  input  logic                 in_vld,
  input  logic [DW-1:0]        in_data,
  output logic                 out_vld,
  output logic [DW-1:0]        out_data,
  output logic signed [SW-1:0] sum_o
);
  localparam int DEPTH = 1 << MAX_M;
  localparam int AW    = MAX_M;
  localparam int CW    = MAX_M + 1;

  logic [DW-1:0]        mem [DEPTH];
  logic [AW-1:0]        wptr_q;
  logic [AW-1:0]        rd_addr;
  logic [CW-1:0]        fill_q;
  logic [CW-1:0]        n_taps;
  logic                 full;
  logic [DW-1:0]        oldest;
  logic signed [SW-1:0] sum_q;
  logic signed [SW-1:0] sum_nx;
  logic signed [SW-1:0] in_ext;
  logic signed [SW-1:0] old_ext;
  logic signed [SW-1:0] avg_w;

  assign n_taps  = CW'(1) << m;
  assign full    = (fill_q >= n_taps);
  assign rd_addr = wptr_q - n_taps[AW-1:0];
  assign oldest  = mem[rd_addr];
  assign in_ext  = {{(SW-DW){in_data[DW-1]}}, in_data};
  assign old_ext = full ? {{(SW-DW){oldest[DW-1]}}, oldest} : '0;
  assign sum_nx  = sum_q + in_ext - old_ext;
  assign avg_w   = sum_nx >>> m;
  assign sum_o   = sum_q;

  always_ff @(posedge clk) begin
    if (in_vld && !clr) mem[wptr_q] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q    <= '0;
      wptr_q   <= '0;
      fill_q   <= '0;
      out_vld  <= 1'b0;
      out_data <= '0;
    end else if (clr) begin
      sum_q    <= '0;
      wptr_q   <= '0;
      fill_q   <= '0;
      out_vld  <= 1'b0;
      out_data <= '0;
    end else if (in_vld) begin
      sum_q    <= sum_nx;
      wptr_q   <= wptr_q + 1'b1;
      fill_q   <= full ? fill_q : fill_q + 1'b1;
      out_vld  <= 1'b1;
      out_data <= avg_w[DW-1:0];
    end else begin
      out_vld  <= 1'b0;
    end
  end
endmodule

// File: rtl/bart_warm.sv
module bart_warm #(
  parameter int MAX_M = 7,
  parameter int EW    = $clog2(MAX_M + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [EW-1:0] m,
  output logic          ready
);
  import bart_pkg::*;

  localparam int CW = MAX_M + 2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] need;

  assign need  = CW'(warm_need(32'(m)));
  assign ready = (cnt_q >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (clr)                 cnt_q <= '0;
    else if (adv && cnt_q < need) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bart_filter.sv
module bart_filter #(
  parameter int DW    = 14,
  parameter int MAX_M = 7,
  parameter int TAP_W = 4,
  parameter int RNG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [DW-1:0]    smp_data,
  input  logic [TAP_W-1:0] tap_log2,
  input  logic [RNG_W-1:0] range_sel,
  output logic             filt_valid,
  output logic [DW-1:0]    filt_data
);
  localparam int EW = $clog2(MAX_M + 1);
  localparam int SW = DW + MAX_M + 1;

  logic                 cfg_clr;
  logic [EW-1:0]        m_eff;
  logic                 s1_vld;
  logic [DW-1:0]        s1_dat;
  logic signed [SW-1:0] s1_sum;
  logic                 s2_vld;
  logic [DW-1:0]        s2_dat;
  logic signed [SW-1:0] s2_sum;
  logic                 warm_ok;

  bart_cfg #(.TAP_W(TAP_W), .RNG_W(RNG_W), .MAX_M(MAX_M), .EW(EW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .tap_req(tap_log2), .rng_req(range_sel),
    .clr(cfg_clr), .m_eff(m_eff)
  );

  // Two identical boxcar stages in series give the triangular response.
  for (genvar g = 0; g < 2; g++) begin : g_stage
    logic          vi;
    logic [DW-1:0] di;
    logic          vo;
    logic [DW-1:0] dout;
    logic signed [SW-1:0] so;
    if (g == 0) begin : g_head
      assign vi = smp_valid;
      assign di = smp_data;
    end else begin : g_tail
      assign vi = s1_vld;
      assign di = s1_dat;
    end
    bart_stage #(.DW(DW), .MAX_M(MAX_M), .EW(EW), .SW(SW)) u_box (
      .clk(clk), .rst_n(rst_n), .clr(cfg_clr), .m(m_eff),
      .in_vld(vi), .in_data(di), .out_vld(vo), .out_data(dout), .sum_o(so)
    );
  end

  assign s1_vld = g_stage[0].vo;
  assign s1_dat = g_stage[0].dout;
  assign s1_sum = g_stage[0].so;
  assign s2_vld = g_stage[1].vo;
  assign s2_dat = g_stage[1].dout;
  assign s2_sum = g_stage[1].so;

  bart_warm #(.MAX_M(MAX_M), .EW(EW)) u_warm (
    .clk(clk), .rst_n(rst_n), .clr(cfg_clr), .adv(s2_vld), .m(m_eff), .ready(warm_ok)
  );

  assign filt_valid = s2_vld & warm_ok & ~cfg_clr;
  assign filt_data  = s2_dat;
endmodule

// File: rtl/bart_filter_chk.sv
module bart_filter_chk #(
  parameter int DW    = 14,
  parameter int MAX_M = 7,
  parameter int EW    = $clog2(MAX_M + 1),
  parameter int SW    = DW + MAX_M + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_valid,
  input logic [DW-1:0]        smp_data,
  input logic                 filt_valid,
  input logic [DW-1:0]        filt_data,
  input logic                 clr,
  input logic [EW-1:0]        m_eff,
  input logic signed [SW-1:0] s1_sum,
  input logic signed [SW-1:0] s2_sum
);
  localparam int AC_W = MAX_M + 3;

  logic [AC_W-1:0] acc_q;
  int need_i;
  int hi_i;
  int lo_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          acc_q <= '0;
    else if (clr)                        acc_q <= '0;
    else if (smp_valid && acc_q != '1)   acc_q <= acc_q + 1'b1;
  end

  always_comb begin
    need_i = (2 << m_eff) - 1;
    hi_i   = ((1 << (DW - 1)) - 1) * (1 << m_eff);
    lo_i   = -(1 << (DW - 1)) * (1 << m_eff);
  end

  // R4
  warm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filt_valid |-> (int'(acc_q) >= need_i));

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_valid && m_eff == '0) |-> (filt_data == $past(smp_data, 2)));

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filt_valid |-> $past(smp_valid, 2));

  // R8
  clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !filt_valid);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(s1_sum) <= hi_i) && (int'(s1_sum) >= lo_i));

  // R9
  no_overflow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(s2_sum) <= hi_i) && (int'(s2_sum) >= lo_i));
endmodule

bind bart_filter bart_filter_chk #(.DW(DW), .MAX_M(MAX_M)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
  .filt_valid(filt_valid), .filt_data(filt_data), .clr(cfg_clr),
  .m_eff(m_eff), .s1_sum(s1_sum), .s2_sum(s2_sum)
);

// File: tb/bart_filter_test.sv
`timescale 1ns/1ps
module bart_filter_test;
  localparam int LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [13:0] smp_data = '0;
  logic [3:0]  tap_log2 = '0;
  logic [2:0]  range_sel = '0;
  logic        filt_valid;
  logic [13:0] filt_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  string cur_tag = "R1";

  int hist [1024];
  int a1 [1024];
  int k_cnt = 0;
  int n_cur = 1;
  int exp_q [$];
  int exp_t [$];
  int lfsr = 32'h1ACE;

  bart_filter uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .tap_log2(tap_log2), .range_sel(range_sel),
    .filt_valid(filt_valid), .filt_data(filt_data)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic int fdiv(input int s, input int n);
    int q;
    q = s / n;
    if ((s % n) != 0 && s < 0) q = q - 1;
    return q;
  endfunction

  // Window length from the requirements (R5, R6, R7).
  function automatic int model_taps(input int t, input int r);
    int m;
    m = (t > 7) ? 7 : t;
    if (r == 1 && m < 4) m = 4;
    if (r == 2 && m < 2) m = 2;
    return 1 << m;
  endfunction

  function automatic void model_add(input int x);
    int s;
    hist[k_cnt] = x;
    s = 0;
    for (int j = k_cnt - n_cur + 1; j <= k_cnt; j++) if (j >= 0) s += hist[j];
    a1[k_cnt] = fdiv(s, n_cur);
    s = 0;
    for (int j = k_cnt - n_cur + 1; j <= k_cnt; j++) if (j >= 0) s += a1[j];
    if (k_cnt >= 2 * n_cur - 2) begin
      exp_q.push_back(fdiv(s, n_cur));
      exp_t.push_back(cyc + 2);
    end
    k_cnt++;
  endfunction

  // Output monitor, sampling away from the rising edge.
  always @(negedge clk) begin
    int ed;
    int et;
    #1;
    if (rst_n && filt_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", 1, 0, "unexpected filt_valid during warm-up");
      end else begin
        ed = exp_q.pop_front();
        et = exp_t.pop_front();
        chk(int'($signed(filt_data)) == ed, cur_tag, int'($signed(filt_data)), ed, "filt_data");
        chk(cyc == et, cur_tag, cyc, et, "output cycle");
      end
    end
  end

  task automatic push(input int x);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data = 14'(x);
    model_add(x);
  endtask

  task automatic gap();
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    gap();
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0, "outputs missing after stream");
    exp_q.delete();
    exp_t.delete();
  endtask

  // Settings change (R8); an optional sample in the same cycle is discarded.
  task automatic setcfg(input int t, input int r, input bit with_smp, input int x);
    @(negedge clk);
    tap_log2 = 4'(t);
    range_sel = 3'(r);
    smp_valid = with_smp;
    smp_data = 14'(x);
    k_cnt = 0;
    n_cur = model_taps(t, r);
    @(negedge clk);
    smp_valid = 1'b0;
    #1;
    chk(filt_valid == 1'b0, "R8", int'(filt_valid), 0, "filt_valid after settings change");
    repeat (2) @(negedge clk);
  endtask

  function automatic int next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >>> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return int'(lfsr[13:0]) - 8192;
  endfunction

  task automatic run(input int pat, input int len);
    for (int i = 0; i < len; i++) begin
      case (pat)
        0: push(next_rand());
        1: push((i % 2 == 0) ? 8191 : -8192);
        default: begin
          push(((i * 997) % 16384) - 8192);
          if (i % 3 == 1) gap();
          if (i % 7 == 3) gap();
        end
      endcase
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(filt_valid == 1'b0, "R1", int'(filt_valid), 0, "filt_valid in reset");
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      #1;
      chk(filt_valid == 1'b0, "R1", int'(filt_valid), 0, "filt_valid after reset");
    end

    for (int m = 0; m < 8; m++) begin
      setcfg(m, 0, 1'b0, 0);
      cur_tag = (m == 0) ? "R2" : "R3";
      run(0, 2 * n_cur + 6);
      drain(cur_tag);
      run(1, 2 * n_cur + 6);
      drain(cur_tag);
      cur_tag = "R10";
      run(2, 2 * n_cur + 6);
      drain("R10");
    end

    setcfg(9, 0, 1'b0, 0);
    cur_tag = "R5";
    run(0, 262);
    drain("R5");

    setcfg(0, 2, 1'b0, 0);
    cur_tag = "R6";
    run(0, 14);
    drain("R6");
    setcfg(3, 2, 1'b0, 0);
    run(0, 22);
    drain("R6");

    setcfg(1, 1, 1'b0, 0);
    cur_tag = "R7";
    run(0, 38);
    drain("R7");
    setcfg(0, 3, 1'b0, 0);
    run(0, 8);
    drain("R7");

    setcfg(7, 0, 1'b0, 0);
    cur_tag = "R9";
    for (int i = 0; i < 260; i++) push(8191);
    for (int i = 0; i < 260; i++) push(-8192);
    drain("R9");

    setcfg(2, 0, 1'b0, 0);
    cur_tag = "R8";
    run(0, 12);
    drain("R8");
    setcfg(4, 0, 1'b1, 8191);
    run(0, 40);
    drain("R8");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(LIMIT * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule